// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether the receive side of a twisted-pair port is alive, and on the transmit side it sends the idle-time link test pulses. All timing is counted in ticks of a one-millisecond strobe, `ms_tick`. The receive path delivers a level, `rx_active`, that is high while a data packet arrives, and a one-cycle strobe, `lp_rx`, for each link test pulse that is seen. The transmit path delivers `tx_active`, which is high while the controller sends. A pulse counts as accepted only when at least `GAP_MIN_MS` ticks have passed since the last accepted pulse. A pulse that comes sooner is dropped and leaves the interval timing as it was.

The controller is built around five states. `ST_PASS` is the idle state, in which the link passes. `ST_FAIL_RESET` clears the pulse count. `ST_FAIL_WAIT` waits for the first accepted pulse. `ST_FAIL` counts accepted pulses. `ST_FAIL_EXT` keeps transmit off until both directions are quiet. The transitions are as follows:
- PASS to FAIL_RESET when the loss timer expires.
- FAIL_RESET to FAIL_WAIT after one cycle.
- FAIL_WAIT to FAIL on an accepted pulse.
- FAIL_WAIT or FAIL to FAIL_EXT on receive data, or when the accepted pulse count reaches `PULSES_NEEDED`.
- FAIL to FAIL_RESET when the gap between pulses grows past `GAP_MAX_MS`.
- FAIL_EXT to PASS when `rx_active` and `tx_active` are both low.
- Any state to PASS when link testing is off or `force_pass` is high.

Top module: `lnk_integ_top`

## Requirements
- R1: After reset the state is PASS: `link_ok`, `xmit_en`, `rcv_en` and `lpbk_en` are all 1 and `lp_tx` is 0.
- R2: With testing enabled, LOSS_MS (60) ticks in PASS without receive data and without an accepted pulse lead to link fail. In link fail `link_ok`, `xmit_en`, `rcv_en` and `lpbk_en` are all 0.
- R3: A pulse that arrives fewer than GAP_MIN_MS (4) ticks after the last accepted pulse is ignored. It is not counted and it does not restart the interval timing.
- R4: In link fail, a second accepted pulse (PULSES_NEEDED = 2) moves the block to FAIL_EXT. With both directions idle, the block then reaches PASS one cycle later.
- R5: While pulses are being counted, a gap of more than GAP_MAX_MS (65) ticks since the last accepted pulse returns the block to FAIL_RESET. This sets the pulse count back to zero.
- R6: Receive data during link fail enters FAIL_EXT. FAIL_EXT drives `rcv_en`=1 and drives `link_ok`, `xmit_en` and `lpbk_en` to 0. It holds until `rx_active` and `tx_active` are both low.
- R7: With testing enabled and `tx_active` low, `lp_tx` pulses high for one cycle every TX_GAP_MS (16) ticks. While `tx_active` is high no pulse is sent and the spacing count restarts from zero.
- R8: With `test_en`=0, no pulses are sent, and the link reaches PASS by the next clock edge and stays there.
- R9: With `force_pass`=1, the link is held at PASS whatever the receive side does, and `lp_tx` pulses continue.
- R10: In PASS, receive data or an accepted pulse restarts the loss timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| rx_active | input | 1 | Receive data packet in progress |
| lp_rx | input | 1 | One-cycle strobe for a received link test pulse |
| tx_active | input | 1 | Controller transmit in progress |
| test_en | input | 1 | Link integrity testing enabled |
| force_pass | input | 1 | Hold the link at pass |
| link_ok | output | 1 | Link pass status |
| xmit_en | output | 1 | Transmit path enable |
| rcv_en | output | 1 | Receive path enable |
| lpbk_en | output | 1 | Normal loopback enable |
| lp_tx | output | 1 | One-cycle request to send a link test pulse |

## Verification
The bench aims at the edges of each timer. At 59 ticks of silence the link must still pass, and one more tick must fail it; a loss counter that is off by one would fail early or late. A pulse two ticks after an accepted one must be dropped. If that pulse were counted, or if it restarted the interval, the next pulse two ticks later would either leave fail too soon or be rejected in turn. A 66-tick gap between two pulses must leave the block still in fail, which catches a pulse count that is never cleared. FAIL_EXT must be held by `tx_active`, which shows whether transmit is released too early. The `lp_tx` spacing is measured at exactly 16 ticks, which exposes a pacer that is off by one.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
    typedef enum logic [2:0] {
        ST_PASS       = 3'd0,
        ST_FAIL_RESET = 3'd1,
        ST_FAIL_WAIT  = 3'd2,
        ST_FAIL       = 3'd3,
        ST_FAIL_EXT   = 3'd4
    } lnk_state_e;
endpackage

// File: rtl/lnk_gap_qual.sv
`timescale 1ns/1ps
// Measures ticks since the last accepted link pulse; rejects pulses that come too soon
// and flags a gap that has grown too long.
module lnk_gap_qual #(
    parameter int GAP_MIN_MS = 4,
    parameter int GAP_MAX_MS = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic lp_rx,
    output logic pulse_ok,
    output logic gap_expired
);
    localparam int SAT = GAP_MAX_MS + 1;
    localparam int GW  = $clog2(SAT + 1);
    localparam logic [GW-1:0] SAT_V = GW'(SAT);
    localparam logic [GW-1:0] MIN_V = GW'(GAP_MIN_MS);

    logic [GW-1:0] gap_q;

    assign pulse_ok    = lp_rx && (gap_q >= MIN_V);
    assign gap_expired = (gap_q == SAT_V);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= SAT_V;
        end else if (pulse_ok) begin
            gap_q <= '0;
        end else if (ms_tick && (gap_q != SAT_V)) begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_tx_pacer.sv
`timescale 1ns/1ps
// Emits a one-cycle link test pulse request every TX_GAP_MS ticks of transmit idle.
module lnk_tx_pacer #(
    parameter int TX_GAP_MS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic test_en,
    input  logic tx_active,
    output logic lp_tx
);
    localparam int TW = (TX_GAP_MS > 2) ? $clog2(TX_GAP_MS) : 1;
    localparam logic [TW-1:0] LAST_V = TW'(TX_GAP_MS - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !test_en || tx_active) begin
            cnt_q <= '0;
            lp_tx <= 1'b0;
        end else begin
            lp_tx <= 1'b0;
            if (ms_tick) begin
                if (cnt_q == LAST_V) begin
                    cnt_q <= '0;
                    lp_tx <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lnk_fsm.sv
`timescale 1ns/1ps
// Link pass/fail controller with loss timer and accepted-pulse count.
module lnk_fsm
    import lnk_pkg::*;
#(
    parameter int LOSS_MS       = 60,
    parameter int PULSES_NEEDED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_active,
    input  logic pulse_ok,
    input  logic gap_expired,
    input  logic tx_active,
    input  logic test_en,
    input  logic force_pass,
    output logic link_ok,
    output logic xmit_en,
    output logic rcv_en,
    output logic lpbk_en
);
    localparam int LW = $clog2(LOSS_MS + 1);
    localparam int PW = $clog2(PULSES_NEEDED + 1);
    localparam logic [LW-1:0] LOSS_V = LW'(LOSS_MS);
    localparam logic [PW:0]   NEED_V = (PW+1)'(PULSES_NEEDED);

    lnk_state_e    state_q, state_d;
    logic [LW-1:0] loss_q;
    logic [PW-1:0] pcnt_q;
    logic [PW:0]   pcnt_inc;
    logic          loss_hit, last_pulse, counting;

    assign loss_hit   = (loss_q >= LOSS_V);
    assign pcnt_inc   = {1'b0, pcnt_q} + 1'b1;
    assign last_pulse = (pcnt_inc >= NEED_V);
    assign counting   = (state_q == ST_FAIL_WAIT) || (state_q == ST_FAIL);

    // next state
    always_comb begin
        state_d = state_q;
        if (!test_en || force_pass) begin
            state_d = ST_PASS;
        end else begin
            unique case (state_q)
                ST_PASS:       if (loss_hit) state_d = ST_FAIL_RESET;
                ST_FAIL_RESET: state_d = ST_FAIL_WAIT;
                ST_FAIL_WAIT: begin
                    if (rx_active)     state_d = ST_FAIL_EXT;
                    else if (pulse_ok) state_d = last_pulse ? ST_FAIL_EXT : ST_FAIL;
                end
                ST_FAIL: begin
                    if (rx_active)                     state_d = ST_FAIL_EXT;
                    else if (gap_expired)              state_d = ST_FAIL_RESET;
                    else if (pulse_ok && last_pulse)   state_d = ST_FAIL_EXT;
                end
                ST_FAIL_EXT:   if (!rx_active && !tx_active) state_d = ST_PASS;
                default:       state_d = ST_PASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // loss timer, active only in pass
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != ST_PASS) || rx_active || pulse_ok ||
            !test_en || force_pass) begin
            loss_q <= '0;
        end else if (ms_tick && !loss_hit) begin
            loss_q <= loss_q + 1'b1;
        end
    end

    // accepted pulse count while in fail
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) begin
            pcnt_q <= '0;
        end else if (pulse_ok && !rx_active && !last_pulse) begin
            pcnt_q <= pcnt_inc[PW-1:0];
        end
    end

    // outputs
    always_comb begin
        link_ok = 1'b0;
        xmit_en = 1'b0;
        rcv_en  = 1'b0;
        lpbk_en = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                link_ok = 1'b1;
                xmit_en = 1'b1;
                rcv_en  = 1'b1;
                lpbk_en = 1'b1;
            end
            ST_FAIL_EXT: rcv_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lnk_integ_top.sv
`timescale 1ns/1ps
module lnk_integ_top #(
    parameter int LOSS_MS       = 60,
    parameter int GAP_MIN_MS    = 4,
    parameter int GAP_MAX_MS    = 65,
    parameter int TX_GAP_MS     = 16,
    parameter int PULSES_NEEDED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_active,
    input  logic lp_rx,
    input  logic tx_active,
    input  logic test_en,
    input  logic force_pass,
    output logic link_ok,
    output logic xmit_en,
    output logic rcv_en,
    output logic lpbk_en,
    output logic lp_tx
);
    logic pulse_ok, gap_expired;

    lnk_gap_qual #(.GAP_MIN_MS(GAP_MIN_MS), .GAP_MAX_MS(GAP_MAX_MS)) u_gap (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .lp_rx(lp_rx),
        .pulse_ok(pulse_ok), .gap_expired(gap_expired)
    );

    lnk_tx_pacer #(.TX_GAP_MS(TX_GAP_MS)) u_pacer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .test_en(test_en),
        .tx_active(tx_active), .lp_tx(lp_tx)
    );

    lnk_fsm #(.LOSS_MS(LOSS_MS), .PULSES_NEEDED(PULSES_NEEDED)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rx_active(rx_active),
        .pulse_ok(pulse_ok), .gap_expired(gap_expired), .tx_active(tx_active),
        .test_en(test_en), .force_pass(force_pass), .link_ok(link_ok),
        .xmit_en(xmit_en), .rcv_en(rcv_en), .lpbk_en(lpbk_en)
    );
endmodule

// File: rtl/lnk_integ_chk.sv
`timescale 1ns/1ps
module lnk_integ_chk (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic rx_active,
    input logic lp_rx,
    input logic tx_active,
    input logic test_en,
    input logic force_pass,
    input logic link_ok,
    input logic xmit_en,
    input logic rcv_en,
    input logic lpbk_en,
    input logic lp_tx
);
    a_r2_fail_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |-> (!xmit_en && !lpbk_en));

    a_r6_ext_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ok) |-> ($past(!rx_active && !tx_active) || $past(!test_en) || $past(force_pass)));

    a_r7_tx_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !lp_tx);

    a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        lp_tx |=> !lp_tx);

    a_r8_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (link_ok && !lp_tx));

    a_r9_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (force_pass && link_ok) |=> link_ok);
endmodule

bind lnk_integ_top lnk_integ_chk u_chk (.*);

// File: tb/sim_lnk_integ_top.sv
`timescale 1ns/1ps
module sim_lnk_integ_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, rx_active = 1'b0, lp_rx = 1'b0, tx_active = 1'b0;
    logic test_en = 1'b1, force_pass = 1'b0;
    logic link_ok, xmit_en, rcv_en, lpbk_en, lp_tx;

    int checks = 0;
    int failures = 0;
    int tick_no = 0;
    int tx_seen = 0;
    int tx_first = -1;
    int tx_second = -1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lnk_integ_top u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rx_active(rx_active),
        .lp_rx(lp_rx), .tx_active(tx_active), .test_en(test_en),
        .force_pass(force_pass), .link_ok(link_ok), .xmit_en(xmit_en),
        .rcv_en(rcv_en), .lpbk_en(lpbk_en), .lp_tx(lp_tx)
    );

    typedef struct packed {
        logic [7:0] ms;
        logic       rxa;
        logic       pls;
        logic [3:0] exp;   // {link_ok, xmit_en, rcv_en, lpbk_en}
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{8'd59, 1'b0, 1'b0, 4'b1111},   // R10 just below loss
        '{8'd1,  1'b0, 1'b0, 4'b0000},   // R2 loss reached
        '{8'd5,  1'b0, 1'b1, 4'b0000},   // R4 first pulse
        '{8'd2,  1'b0, 1'b1, 4'b0000},   // R3 too-early pulse dropped
        '{8'd2,  1'b0, 1'b1, 4'b1111},   // R4 second pulse -> pass
        '{8'd59, 1'b0, 1'b1, 4'b1111},   // R10 pulse restarts loss
        '{8'd59, 1'b0, 1'b0, 4'b1111},   // R10
        '{8'd1,  1'b0, 1'b0, 4'b0000},   // R2
        '{8'd3,  1'b1, 1'b0, 4'b0010},   // R6 data in fail -> extended
        '{8'd1,  1'b0, 1'b0, 4'b1111},   // R6 release when idle
        '{8'd60, 1'b0, 1'b0, 4'b0000},   // R2
        '{8'd1,  1'b0, 1'b1, 4'b0000},   // R5 first pulse
        '{8'd66, 1'b0, 1'b1, 4'b0000},   // R5 stale gap restarts count
        '{8'd10, 1'b0, 1'b1, 4'b1111},   // R4
        '{8'd70, 1'b1, 1'b0, 4'b1111},   // R10 data keeps pass
        '{8'd1,  1'b0, 1'b0, 4'b1111}    // R10
    };
    string row_req [16] = '{"R10","R2","R4","R3","R4","R10","R10","R2",
                            "R6","R6","R2","R5","R5","R4","R10","R10"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {link_ok, xmit_en, rcv_en, lpbk_en};
        chk(act == exp, req, int'(act), int'(exp));
    endtask

    task automatic ticks(input int n, input logic rxa);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_active = rxa;
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            tick_no++;
            if (lp_tx) begin
                tx_seen++;
                if (tx_first < 0) tx_first = tick_no;
                else if (tx_second < 0) tx_second = tick_no;
            end
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        lp_rx = 1'b1;
        @(negedge clk);
        lp_rx = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_active = 1'b0; lp_rx = 1'b0; tx_active = 1'b0; ms_tick = 1'b0;
        test_en = 1'b1; force_pass = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_no = 0; tx_seen = 0; tx_first = -1; tx_second = -1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #750000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_out(4'b1111, "R1");
        chk(lp_tx == 1'b0, "R1", int'(lp_tx), 0);

        // vector table
        for (int k = 0; k < 16; k++) begin
            ticks(int'(VEC[k].ms), VEC[k].rxa);
            if (VEC[k].pls) pulse();
            settle();
            chk_out(VEC[k].exp, row_req[k]);
        end

        // R7 spacing of transmitted pulses
        do_reset();
        ticks(40, 1'b0);
        chk(tx_seen == 2, "R7", tx_seen, 2);
        chk(tx_first == 16, "R7", tx_first, 16);
        chk(tx_second == 32, "R7", tx_second, 32);

        // R7 no pulses while transmitting
        do_reset();
        tx_active = 1'b1;
        ticks(40, 1'b0);
        chk(tx_seen == 0, "R7", tx_seen, 0);

        // R8 testing disabled: no pulses and the link passes
        do_reset();
        test_en = 1'b0;
        ticks(80, 1'b0);
        settle();
        chk(tx_seen == 0, "R8", tx_seen, 0);
        chk_out(4'b1111, "R8");

        // R8 disabling testing while in fail returns to pass
        do_reset();
        ticks(60, 1'b0);
        settle();
        chk_out(4'b0000, "R8");
        test_en = 1'b0;
        repeat (2) @(negedge clk);
        chk_out(4'b1111, "R8");

        // R9 forced pass holds and pulses continue
        do_reset();
        force_pass = 1'b1;
        ticks(80, 1'b0);
        settle();
        chk_out(4'b1111, "R9");
        chk(tx_seen == 5, "R9", tx_seen, 5);

        // R6 extended state held by transmit activity
        do_reset();
        ticks(60, 1'b0);
        settle();
        tx_active = 1'b1;
        pulse();
        ticks(5, 1'b0);
        pulse();
        settle();
        chk_out(4'b0010, "R6");
        tx_active = 1'b0;
        repeat (2) @(negedge clk);
        chk_out(4'b1111, "R6");

        finish_run();
    end
endmodule